// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block forms the byte a flash device returns on reads while an internal program or erase runs, or while a sector erase is paused. It takes the current operation kind, bit 7 of the byte being written, the sector under erase, the sector of the read address, a read strobe, a timeout level from the operation timer, and the array byte at the read address. From these it drives the status byte on `rd_data`.

Each status bit follows its own rule:

- Bit 7 reports completion polarity.
- Bit 6 flips on every new read while work is in progress.
- Bit 5 latches a timing fault.
- Bit 3 marks a started erase.
- Bit 2 flips only for reads that touch the sector being erased.

Bits with no status meaning carry the array byte. When no operation is active, the whole byte is the array byte.

Toggle state advances once per rising edge of `rd_stb`, not on each clock, so a held read returns a steady value. The output is combinational from the inputs and the toggle and error registers. It therefore reflects a toggle in the cycle after the clock edge that captured the strobe's rise. The `op_kind` encoding is: 0 idle, 1 byte program, 2 sector erase, 3 chip erase, 4 erase suspended.

Top module: `embop_status`

## Requirements
- R1: With `op_kind` = 0 (idle), `rd_data` equals `arr_data` in all eight bits.
- R2: With `op_kind` = 1 (program), bit 7 of `rd_data` is the complement of `wr_bit7`.
- R3: With `op_kind` = 2 or 3 (erase), bit 7 of `rd_data` is 0 and bit 3 is 1.
- R4: With `op_kind` 1, 2 or 3, bit 6 inverts once at each rising edge of `rd_stb`, at any address. While `rd_stb` is held high it does not change.
- R5: With `op_kind` 0 or 4, a read does not change bit 6.
- R6: In sector erase (`op_kind` 2), bit 2 inverts at a rising edge of `rd_stb` only when `rd_sector` equals `er_sector`. In chip erase (`op_kind` 3), it inverts on every read whatever the address.
- R7: `timeout` seen high while `op_kind` is 1, 2 or 3 sets bit 5. Bit 5 stays 1 while any non-idle operation lasts, even after `timeout` falls. It clears once `op_kind` returns to 0.
- R8: With `op_kind` = 4, a read outside the suspended sector returns `arr_data`. A read inside it returns bit 7 = 1, inverts bit 2 per read, and holds bit 6.
- R9: Status-free bits carry `arr_data`: bits 4..0 during program, and bits 4, 1 and 0 during erase.
- R10: Reset clears the bit 6 toggle, the bit 2 toggle and the error latch to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_kind | input | 3 | Operation kind: 0 idle, 1 program, 2 sector erase, 3 chip erase, 4 erase suspended |
| wr_bit7 | input | 1 | Bit 7 of the byte being programmed |
| er_sector | input | 3 | Sector under erase or suspended erase |
| rd_sector | input | 3 | Sector of the current read address |
| rd_stb | input | 1 | Read strobe, high for the duration of a read |
| timeout | input | 1 | Operation time limit exceeded |
| arr_data | input | 8 | Array byte at the read address |
| rd_data | output | 8 | Byte returned to the reader |

## Verification
The assertions take for granted that `op_kind` holds one of the five defined codes. They also assume `rd_stb` is a level that is sampled synchronously, with its rise meaning a new read. The stimulus changes every input only on the falling clock edge and uses only codes 0 to 4. It holds `op_kind` steady across each read pulse, so a toggle is never credited to an operation that ended within the same cycle. The bench predicts every toggle value from its own count of strobe rises per operation kind.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int DATA_W = 8;
  localparam int SECT_W = 3;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_CERASE = 3'd3,
    OP_SUSP   = 3'd4
  } op_e;

  localparam int BIT_POLL  = 7;
  localparam int BIT_TOG   = 6;
  localparam int BIT_ERR   = 5;
  localparam int BIT_START = 3;
  localparam int BIT_SECT  = 2;
endpackage

// File: rtl/sgen_sector_cmp.sv
module sgen_sector_cmp #(
  parameter int SECT_W = 3
) (
  input  logic [SECT_W-1:0] sect_a,
  input  logic [SECT_W-1:0] sect_b,
  output logic              same
);
  logic [SECT_W-1:0] diff;
  for (genvar i = 0; i < SECT_W; i++) begin : g_bit
    assign diff[i] = sect_a[i] ^ sect_b[i];
  end
  assign same = ~|diff;
endmodule

// File: rtl/sgen_toggle.sv
module sgen_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic adv_main,
  input  logic adv_sect,
  output logic tog_main,
  output logic tog_sect
);
  logic stb_q;
  logic stb_rise;

  assign stb_rise = rd_stb & ~stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q    <= 1'b0;
      tog_main <= 1'b0;
      tog_sect <= 1'b0;
    end else begin
      stb_q    <= rd_stb;
      tog_main <= tog_main ^ (stb_rise & adv_main);
      tog_sect <= tog_sect ^ (stb_rise & adv_sect);
    end
  end

  AST_HELD_READ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stb && stb_q) |-> ($stable(tog_main) && $stable(tog_sect))); // R4

  AST_MAIN_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_main |=> $stable(tog_main)); // R5
endmodule

// File: rtl/sgen_err_latch.sv
module sgen_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic active,
  input  logic timeout,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (!active) err <= 1'b0;
    else              err <= err | (busy & timeout);
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && active) |=> err); // R7

  AST_ERR_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(timeout && busy)); // R7
endmodule

// File: rtl/sgen_mux.sv
module sgen_mux
  import status_pkg::*;
(
  input  op_e               op,
  input  logic              wr_bit7,
  input  logic              hit,
  input  logic              tog_main,
  input  logic              tog_sect,
  input  logic              err,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = arr_data;
    unique case (op)
      OP_PROG: begin
        rd_data[BIT_POLL] = ~wr_bit7;
        rd_data[BIT_TOG]  = tog_main;
        rd_data[BIT_ERR]  = err;
      end
      OP_SERASE, OP_CERASE: begin
        rd_data[BIT_POLL]  = 1'b0;
        rd_data[BIT_TOG]   = tog_main;
        rd_data[BIT_ERR]   = err;
        rd_data[BIT_START] = 1'b1;
        rd_data[BIT_SECT]  = tog_sect;
      end
      OP_SUSP: begin
        if (hit) begin
          rd_data[BIT_POLL] = 1'b1;
          rd_data[BIT_TOG]  = tog_main;
          rd_data[BIT_SECT] = tog_sect;
        end
      end
      default: rd_data = arr_data;
    endcase
  end
endmodule

// File: rtl/embop_status.sv
module embop_status
  import status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_kind,
  input  logic              wr_bit7,
  input  logic [SECT_W-1:0] er_sector,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic              rd_stb,
  input  logic              timeout,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);
  op_e  op;
  logic hit;
  logic busy;
  logic active;
  logic adv_sect;
  logic tog_main;
  logic tog_sect;
  logic err;

  assign op     = op_e'(op_kind);
  assign busy   = (op == OP_PROG) || (op == OP_SERASE) || (op == OP_CERASE);
  assign active = (op != OP_IDLE);

  sgen_sector_cmp #(.SECT_W(SECT_W)) i_cmp (
    .sect_a (er_sector),
    .sect_b (rd_sector),
    .same   (hit)
  );

  assign adv_sect = (op == OP_CERASE) ||
                    (((op == OP_SERASE) || (op == OP_SUSP)) && hit);

  sgen_toggle i_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .adv_main (busy),
    .adv_sect (adv_sect),
    .tog_main (tog_main),
    .tog_sect (tog_sect)
  );

  sgen_err_latch i_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .active  (active),
    .timeout (timeout),
    .err     (err)
  );

  sgen_mux i_mux (
    .op       (op),
    .wr_bit7  (wr_bit7),
    .hit      (hit),
    .tog_main (tog_main),
    .tog_sect (tog_sect),
    .err      (err),
    .arr_data (arr_data),
    .rd_data  (rd_data)
  );

  AST_ERASE_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_kind == 3'd2) || (op_kind == 3'd3)) |-> (rd_data[BIT_START] && !rd_data[BIT_POLL])); // R3

  AST_SUSP_OUTSIDE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_kind == 3'd4) && (rd_sector != er_sector)) |-> (rd_data == arr_data)); // R8

  AST_SECT_TOGGLE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_kind == 3'd2) && (rd_sector != er_sector)) |=> $stable(tog_sect)); // R6
endmodule

// File: tb/test_embop_status.sv
module test_embop_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_kind = 3'd0;
  logic       wr_bit7 = 1'b0;
  logic [2:0] er_sector = 3'd0;
  logic [2:0] rd_sector = 3'd0;
  logic       rd_stb = 1'b0;
  logic       timeout = 1'b0;
  logic [7:0] arr_data = 8'h00;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  embop_status i_embop_status (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .wr_bit7(wr_bit7),
    .er_sector(er_sector), .rd_sector(rd_sector), .rd_stb(rd_stb),
    .timeout(timeout), .arr_data(arr_data), .rd_data(rd_data)
  );

  // {op, wr_bit7, er_sector, rd_sector, arr_data, expected}
  localparam logic [25:0] VEC [8] = '{
    {3'd0, 1'b0, 3'd0, 3'd0, 8'hA5, 8'hA5},
    {3'd1, 1'b1, 3'd0, 3'd0, 8'h3C, 8'h1C},
    {3'd1, 1'b0, 3'd0, 3'd0, 8'h00, 8'h80},
    {3'd2, 1'b0, 3'd2, 3'd2, 8'hFF, 8'h1B},
    {3'd2, 1'b0, 3'd2, 3'd5, 8'h00, 8'h08},
    {3'd3, 1'b0, 3'd0, 3'd7, 8'hFF, 8'h1B},
    {3'd4, 1'b0, 3'd1, 3'd4, 8'h5A, 8'h5A},
    {3'd4, 1'b0, 3'd1, 3'd1, 8'h00, 8'h80}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk) rd_stb = 1'b1;
    @(posedge clk);
    #1 v = rd_data;
    @(negedge clk) rd_stb = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    logic [7:0] v;
    logic       exp6;
    logic       exp2;

    arr_data = 8'h3C;
    repeat (3) @(posedge clk);
    #1 check("R1 reset idle passthrough", rd_data, 8'h3C);
    @(negedge clk) rst_n = 1'b1;

    // Vector table: toggles and error are still at reset values
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {op_kind, wr_bit7, er_sector, rd_sector, arr_data} = VEC[i][25:8];
      #1 check($sformatf("R1/R2/R3/R8/R9 vector %0d", i), rd_data, VEC[i][7:0]);
    end

    // R4: program, DQ6 alternates starting from reset value 0
    @(negedge clk) begin op_kind = 3'd1; wr_bit7 = 1'b0; arr_data = 8'h00; end
    exp6 = 1'b0;
    for (int i = 0; i < 4; i++) begin
      do_read(v);
      exp6 = ~exp6;
      check("R4 program toggle", {7'd0, v[6]}, {7'd0, exp6});
    end

    // R4: held strobe keeps DQ6 steady
    @(negedge clk) rd_stb = 1'b1;
    @(posedge clk);
    exp6 = ~exp6;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R4 held strobe", {7'd0, rd_data[6]}, {7'd0, exp6});
    end
    @(negedge clk) rd_stb = 1'b0;

    // R5: idle reads do not advance DQ6
    @(negedge clk) op_kind = 3'd0;
    for (int i = 0; i < 3; i++) begin
      do_read(v);
      check("R1 idle read", v, 8'h00);
    end
    @(negedge clk) op_kind = 3'd1;
    #1 check("R5 idle left DQ6 unchanged", {7'd0, rd_data[6]}, {7'd0, exp6});

    // R6: sector erase, read in erased sector; DQ2 starts at 0
    @(negedge clk) begin op_kind = 3'd2; er_sector = 3'd3; rd_sector = 3'd3; end
    exp2 = 1'b0;
    for (int i = 0; i < 3; i++) begin
      do_read(v);
      exp2 = ~exp2; exp6 = ~exp6;
      check("R6 DQ2 in erased sector", {7'd0, v[2]}, {7'd0, exp2});
      check("R4 DQ6 during erase", {7'd0, v[6]}, {7'd0, exp6});
    end
    @(negedge clk) rd_sector = 3'd6;
    for (int i = 0; i < 2; i++) begin
      do_read(v);
      exp6 = ~exp6;
      check("R6 DQ2 outside erased sector", {7'd0, v[2]}, {7'd0, exp2});
      check("R4 DQ6 any address", {7'd0, v[6]}, {7'd0, exp6});
    end
    @(negedge clk) op_kind = 3'd3;
    for (int i = 0; i < 2; i++) begin
      do_read(v);
      exp2 = ~exp2; exp6 = ~exp6;
      check("R6 DQ2 chip erase any address", {7'd0, v[2]}, {7'd0, exp2});
    end

    // R8: suspended, inside suspended sector
    @(negedge clk) begin op_kind = 3'd4; rd_sector = 3'd3; arr_data = 8'h00; end
    for (int i = 0; i < 2; i++) begin
      do_read(v);
      exp2 = ~exp2;
      check("R8 suspend DQ2 toggles", {7'd0, v[2]}, {7'd0, exp2});
      check("R8/R5 suspend DQ6 steady", {7'd0, v[6]}, {7'd0, exp6});
      check("R8 suspend DQ7 high", {7'd0, v[7]}, 8'd1);
    end
    @(negedge clk) begin rd_sector = 3'd0; arr_data = 8'hC3; end
    do_read(v);
    check("R8 suspend other sector", v, 8'hC3);

    // R7: sticky error
    @(negedge clk) begin op_kind = 3'd1; arr_data = 8'h00; wr_bit7 = 1'b1; end
    #1 check("R7 error clear before timeout", {7'd0, rd_data[5]}, 8'd0);
    @(negedge clk) timeout = 1'b1;
    @(negedge clk) timeout = 1'b0;
    #1 check("R7 error set", {7'd0, rd_data[5]}, 8'd1);
    repeat (3) @(negedge clk);
    check("R7 error held", {7'd0, rd_data[5]}, 8'd1);
    check("R2 program DQ7", {7'd0, rd_data[7]}, 8'd0);
    @(negedge clk) op_kind = 3'd0;
    @(negedge clk) op_kind = 3'd1;
    #1 check("R7 error cleared by idle", {7'd0, rd_data[5]}, 8'd0);

    // R10: reset clears toggles and error
    @(negedge clk) timeout = 1'b1;
    @(negedge clk) timeout = 1'b0;
    do_read(v);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) begin rst_n = 1'b1; op_kind = 3'd3; arr_data = 8'h00; end
    #1 check("R10 reset state", rd_data, 8'h08);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule